// File: doc/BRIEF.md
# Strobed Capture Memory Controller

This block records a run of samples from an external data bus into an on-chip capture memory. Capture is armed by raising a capture enable. Each pulse on a single capture strobe then stores one sample, with one edge of the pulse writing the bus value at the current address and the other edge moving the address counter on. The counter is built from cascaded narrow counter stages. When the last address has been consumed, a full flag is raised and further pulses are ignored, so earlier samples are never overwritten.

When capture enable is low, an address multiplexer hands the memory address to a host port so that a host processor can read the captured samples back. A status readout shows the counter position and the full flag. If the host stops a capture before the memory fills, the status therefore shows how many samples were taken. A memory-select input acts as the memory chip enable, and a read-enable input gates the read-data output.

Top module: `cap_ram_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it, `stat_addr` is 0, `stat_full` is 0 and `host_rd_data` is 0.
- R2: A clock edge that samples `cap_en` high after it was low at the previous edge arms the capture. `stat_addr` becomes 0 and `stat_full` becomes 0 after that edge. A strobe transition seen at the arming edge has no effect.
- R3: While capture is active (`cap_en` high at this edge and the previous edge), a 0-to-1 transition of `cap_strobe` writes `cap_data` into memory entry `stat_addr`, provided `mem_sel` is high and `stat_full` is 0. `stat_addr` does not change on that edge.
- R4: While capture is active and `stat_full` is 0, a 1-to-0 transition of `cap_strobe` increments `stat_addr` by one. This happens whatever the level of `mem_sel`.
- R5: A 1-to-0 transition of `cap_strobe` at address 4095 sets `stat_full`, and `stat_addr` stays at 4095. While `stat_full` is 1, strobes neither write nor advance, until the next arm.
- R6: Strobe transitions while `cap_en` is low change neither the counter, the full flag nor the memory contents.
- R7: With `cap_en` low and `mem_sel` high, the edge reads memory entry `host_addr`. The value appears on `host_rd_data` after that edge while `host_rd_en` is high.
- R8: While `host_rd_en` is low, `host_rd_data` is 0.
- R9: While `mem_sel` is low, nothing is written to memory and the read register keeps its previous value.
- R10: When `cap_en` drops before the memory fills, `stat_addr` keeps the position where capture stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable; rising level arms, low hands the memory to the host |
| cap_strobe | input | 1 | Capture strobe; the rising edge writes and the falling edge advances |
| cap_data | input | 8 | External bus sampled into memory |
| mem_sel | input | 1 | Memory chip enable |
| host_addr | input | 12 | Host read address |
| host_rd_en | input | 1 | Read-data output enable |
| host_rd_data | output | 8 | Read data, zero when not enabled |
| stat_addr | output | 12 | Current capture counter position |
| stat_full | output | 1 | Memory has been filled |

## Verification
Short captures use random sample values, random gaps between the strobe edges and random pulse counts. These show whether writes land on the edge that carries the data and whether the counter moves only on the opposite edge. Strobes sent while capture is disabled or deselected, a strobe that rises in the same cycle as arming, and a capture cut short are each followed by a read-back. The read-back tells a skipped write apart from a misplaced one. A run of 4101 pulses separates a correct stop at 4095 from a counter that wraps or overwrites the last entry.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;
   // Which strobe transition stores the sample; the other one advances.
   typedef enum logic {
      WR_ON_RISE = 1'b0,
      WR_ON_FALL = 1'b1
   } wr_edge_e;

   localparam int unsigned STAGE_W_DEF = 4;
endpackage

// File: rtl/cap_cnt_stage.sv
`timescale 1ns/1ps
// One cascadable counter slice with carry in, freeze and carry out.
module cap_cnt_stage #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic         hold,
   output logic [W-1:0] q,
   output logic         co
);
   initial begin
      if (W < 1) $error("cap_cnt_stage: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (clr) begin
         q <= '0;
      end else if (inc && !hold) begin
         q <= q + 1'b1;
      end
   end

   // Carry ripples whenever this slice is at its top value.
   assign co = inc & (&q);
endmodule

// File: rtl/cap_addr_cnt.sv
`timescale 1ns/1ps
// Capture address counter: slices in cascade, saturating with a full flag.
module cap_addr_cnt #(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned STAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   output logic [ADDR_W-1:0] count,
   output logic              full
);
   localparam int unsigned NSTG = ADDR_W / STAGE_W;

   logic [NSTG:0] carry;
   logic          at_max;
   logic          set_full;

   generate
      if ((ADDR_W % STAGE_W) != 0 || NSTG < 1) begin : g_bad_cfg
         $error("cap_addr_cnt: ADDR_W must be a multiple of STAGE_W");
      end
   endgenerate

   assign at_max   = &count;
   assign carry[0] = adv & ~full;

   genvar g;
   generate
      for (g = 0; g < NSTG; g++) begin : g_stage
         cap_cnt_stage #(.W(STAGE_W)) u_stg (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .inc  (carry[g]),
            .hold (at_max),
            .q    (count[g*STAGE_W +: STAGE_W]),
            .co   (carry[g+1])
         );
      end
   endgenerate

   // The carry out of the last slice fires only on an advance at the top address.
   assign set_full = carry[NSTG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
      end else if (clr) begin
         full <= 1'b0;
      end else if (set_full) begin
         full <= 1'b1;
      end
   end
endmodule

// File: rtl/cap_strobe_edge.sv
`timescale 1ns/1ps
// Arming and strobe edge detection; the edge that writes is a parameter.
module cap_strobe_edge #(
   parameter cap_pkg::wr_edge_e WR_EDGE = cap_pkg::WR_ON_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_en,
   input  logic strobe,
   output logic arm,
   output logic wr_edge,
   output logic adv_edge
);
   logic en_q;
   logic strb_q;
   logic active;
   logic rise;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         strb_q <= 1'b0;
      end else begin
         en_q   <= cap_en;
         strb_q <= strobe;
      end
   end

   assign arm    = cap_en & ~en_q;
   assign active = cap_en & en_q;
   assign rise   = active & strobe & ~strb_q;
   assign fall   = active & ~strobe & strb_q;

   generate
      if (WR_EDGE == cap_pkg::WR_ON_RISE) begin : g_wr_rise
         assign wr_edge  = rise;
         assign adv_edge = fall;
      end else begin : g_wr_fall
         assign wr_edge  = fall;
         assign adv_edge = rise;
      end
   endgenerate
endmodule

// File: rtl/cap_mem.sv
`timescale 1ns/1ps
// Single-port synchronous capture memory with a registered read port.
module cap_mem #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] arr [DEPTH];

   always_ff @(posedge clk) begin
      if (ce && we) begin
         arr[addr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (ce && !we) begin
         rdata <= arr[addr];
      end
   end
endmodule

// File: rtl/cap_ram_ctrl.sv
`timescale 1ns/1ps
// Capture memory controller: strobed capture, saturating counter, host read-back.
module cap_ram_ctrl #(
   parameter int unsigned       ADDR_W  = 12,
   parameter int unsigned       DATA_W  = 8,
   parameter int unsigned       STAGE_W = cap_pkg::STAGE_W_DEF,
   parameter cap_pkg::wr_edge_e WR_EDGE = cap_pkg::WR_ON_RISE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              cap_strobe,
   input  logic [DATA_W-1:0] cap_data,
   input  logic              mem_sel,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_rd_en,
   output logic [DATA_W-1:0] host_rd_data,
   output logic [ADDR_W-1:0] stat_addr,
   output logic              stat_full
);
   initial begin
      if (DATA_W < 1) $error("cap_ram_ctrl: DATA_W must be at least 1");
      if (ADDR_W < 1 || ADDR_W > 16) $error("cap_ram_ctrl: ADDR_W out of range");
   end

   logic              arm_w;
   logic              wr_edge_w;
   logic              adv_edge_w;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_rdata;
   logic [ADDR_W-1:0] cnt_w;
   logic              full_w;

   cap_strobe_edge #(.WR_EDGE(WR_EDGE)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (cap_en),
      .strobe  (cap_strobe),
      .arm     (arm_w),
      .wr_edge (wr_edge_w),
      .adv_edge(adv_edge_w)
   );

   cap_addr_cnt #(.ADDR_W(ADDR_W), .STAGE_W(STAGE_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (arm_w),
      .adv  (adv_edge_w),
      .count(cnt_w),
      .full (full_w)
   );

   // Address multiplexer: capture counter while enabled, host otherwise.
   assign mem_addr = cap_en ? cnt_w : host_addr;
   assign mem_we   = wr_edge_w & ~full_w & mem_sel;

   cap_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk  (clk),
      .rst_n(rst_n),
      .ce   (mem_sel),
      .we   (mem_we),
      .addr (mem_addr),
      .wdata(cap_data),
      .rdata(mem_rdata)
   );

   assign host_rd_data = host_rd_en ? mem_rdata : '0;
   assign stat_addr    = cnt_w;
   assign stat_full    = full_w;
endmodule

// File: rtl/cap_ram_ctrl_chk.sv
`timescale 1ns/1ps
module cap_ram_ctrl_chk #(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cap_en,
   input logic              mem_sel,
   input logic              arm,
   input logic              wr_edge,
   input logic              adv_edge,
   input logic              mem_we,
   input logic [ADDR_W-1:0] stat_addr,
   input logic              stat_full
);
   localparam logic [ADDR_W-1:0] TOP = '1;
   localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_state: assert (stat_addr == '0 && !stat_full)
            else $error("a_r1_reset_state");
      end
   end

   a_r2_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (stat_addr == '0 && !stat_full));

   a_r3_write_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_edge && !arm) |=> $stable(stat_addr));

   a_r3_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
      stat_full |-> !mem_we);

   a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_edge && !stat_full && stat_addr != TOP) |=> stat_addr == $past(stat_addr) + ONE);

   a_r5_full_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_edge && !stat_full && stat_addr == TOP) |=> (stat_full && stat_addr == TOP));

   a_r5_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_full && !arm) |=> (stat_full && $stable(stat_addr)));

   a_r5_full_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      stat_full |-> stat_addr == TOP);

   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> ($stable(stat_addr) && $stable(stat_full)));

   a_r9_no_write_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_sel |-> !mem_we);
endmodule

bind cap_ram_ctrl cap_ram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cap_en   (cap_en),
   .mem_sel  (mem_sel),
   .arm      (arm_w),
   .wr_edge  (wr_edge_w),
   .adv_edge (adv_edge_w),
   .mem_we   (mem_we),
   .stat_addr(stat_addr),
   .stat_full(stat_full)
);

// File: tb/cap_ram_ctrl_tb.sv
`timescale 1ns/1ps
module cap_ram_ctrl_tb;
   localparam int AW    = 12;
   localparam int DW    = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en_i = 1'b0;
   logic          s_i = 1'b0;
   logic [DW-1:0] d_i = '0;
   logic          sel_i = 1'b0;
   logic [AW-1:0] ha_i = '0;
   logic          re_i = 1'b0;
   logic [DW-1:0] rd_o;
   logic [AW-1:0] st_addr;
   logic          st_full;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference state, built from the requirements.
   int            m_cnt = 0;
   bit            m_full = 1'b0;
   bit            m_pen = 1'b0;
   bit            m_ps = 1'b0;
   logic [DW-1:0] m_mem [DEPTH];
   bit            m_val [DEPTH];
   logic [DW-1:0] m_rdq = '0;
   bit            m_rdq_ok = 1'b1;

   always #2.5 clk = ~clk;

   cap_ram_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cap_en(en_i), .cap_strobe(s_i), .cap_data(d_i),
      .mem_sel(sel_i), .host_addr(ha_i), .host_rd_en(re_i),
      .host_rd_data(rd_o), .stat_addr(st_addr), .stat_full(st_full)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Next state of the reference model for one clock edge.
   task automatic model_edge();
      bit arm, act, rise, fall, we;
      arm  = en_i && !m_pen;
      act  = en_i && m_pen;
      rise = act && s_i && !m_ps;
      fall = act && !s_i && m_ps;
      we   = rise && !m_full && sel_i;
      if (sel_i && !we) begin
         if (!en_i) begin
            m_rdq    = m_mem[ha_i];
            m_rdq_ok = m_val[ha_i];
         end else begin
            m_rdq_ok = 1'b0;
         end
      end
      if (we) begin
         m_mem[m_cnt] = d_i;
         m_val[m_cnt] = 1'b1;
      end
      if (arm) begin
         m_cnt  = 0;
         m_full = 1'b0;
      end else if (fall && !m_full) begin
         if (m_cnt == DEPTH - 1) m_full = 1'b1;
         else m_cnt++;
      end
      m_pen = en_i;
      m_ps  = s_i;
   endtask

   // One clock with the current inputs; status and read data checked 1 ns after the edge.
   task automatic cyc(input string tag);
      @(posedge clk);
      model_edge();
      #1;
      check({tag, " stat_addr"}, int'(st_addr), m_cnt);
      check({tag, " stat_full"}, int'(st_full), int'(m_full));
      if (!re_i) check("R8 rd gated", int'(rd_o), 0);
      else if (m_rdq_ok) check("R7 rd data", int'(rd_o), int'(m_rdq));
   endtask

   task automatic drive(input bit en, input bit s, input logic [DW-1:0] d, input bit sel);
      @(negedge clk);
      en_i = en; s_i = s; d_i = d; sel_i = sel;
   endtask

   task automatic pulse(input string tag, input logic [DW-1:0] d, input bit sel, input int gap);
      drive(en_i, 1'b1, d, sel);
      cyc(tag);
      for (int k = 0; k < gap; k++) cyc(tag);
      drive(en_i, 1'b0, $urandom, sel);
      cyc(tag);
      for (int k = 0; k < gap; k++) cyc(tag);
   endtask

   task automatic arm_capture(input string tag);
      drive(1'b0, 1'b0, '0, 1'b1);
      cyc(tag);
      drive(1'b1, 1'b0, '0, 1'b1);
      cyc(tag);
   endtask

   task automatic host_read(input int a, input bit re);
      @(negedge clk);
      en_i = 1'b0; sel_i = 1'b1; ha_i = AW'(a); re_i = re; s_i = 1'b0;
      cyc("R7");
   endtask

   initial begin
      int n;
      n = $urandom(32'd20240611);
      for (int i = 0; i < DEPTH; i++) begin
         m_mem[i] = '0;
         m_val[i] = 1'b0;
      end
      // R1: reset values.
      repeat (3) @(posedge clk);
      #1;
      check("R1 addr in reset", int'(st_addr), 0);
      check("R1 full in reset", int'(st_full), 0);
      check("R1 rd in reset", int'(rd_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc("R1");

      // R3/R4: randomized short captures.
      for (int r = 0; r < 3; r++) begin
         arm_capture("R2");
         n = 10 + int'($urandom_range(20));
         for (int p = 0; p < n; p++) pulse("R4", DW'($urandom), 1'b1, int'($urandom_range(2)));
         check("R3 count after capture", int'(st_addr), n);
         // R10: stop early and hold position.
         drive(1'b0, 1'b0, '0, 1'b1);
         cyc("R10");
         cyc("R10");
         check("R10 stop position", int'(st_addr), n);
         // R6: strobes while disabled are ignored.
         for (int p = 0; p < 4; p++) pulse("R6", DW'($urandom), 1'b1, 0);
         check("R6 count unchanged", int'(st_addr), n);
         for (int a = 0; a < n; a++) host_read(a, 1'b1);
         host_read(0, 1'b0);
      end

      // R9: deselected strobe writes nothing; deselected read keeps data.
      arm_capture("R2");
      pulse("R3", 8'hA5, 1'b1, 0);
      pulse("R9", 8'h3C, 1'b0, 0);
      pulse("R3", 8'h96, 1'b1, 1);
      check("R9 count still advanced", int'(st_addr), 3);
      drive(1'b0, 1'b0, '0, 1'b1);
      cyc("R9");
      host_read(1, 1'b1);
      check("R9 old entry kept", int'(rd_o), int'(m_mem[1]));
      @(negedge clk);
      sel_i = 1'b0; ha_i = AW'(2);
      cyc("R9");
      check("R9 rd held when deselected", int'(rd_o), int'(m_mem[1]));
      host_read(2, 1'b1);
      check("R3 entry 2", int'(rd_o), 8'h96);

      // R2: strobe rising in the arming cycle is ignored; its fall advances.
      drive(1'b0, 1'b0, '0, 1'b1);
      cyc("R2");
      drive(1'b1, 1'b1, 8'hEE, 1'b1);
      cyc("R2");
      check("R2 armed count", int'(st_addr), 0);
      drive(1'b1, 1'b0, 8'h11, 1'b1);
      cyc("R2");
      check("R2 fall after arm", int'(st_addr), 1);
      drive(1'b0, 1'b0, '0, 1'b1);
      cyc("R2");
      host_read(0, 1'b1);
      check("R2 entry 0 not written", int'(rd_o), 8'hA5);

      // R5: fill the memory and keep strobing.
      arm_capture("R2");
      for (int p = 0; p < DEPTH + 5; p++) pulse("R5", DW'((p * 7 + 3) & 255), 1'b1, 0);
      check("R5 full flag", int'(st_full), 1);
      check("R5 parked at top", int'(st_addr), DEPTH - 1);
      drive(1'b0, 1'b0, '0, 1'b1);
      cyc("R5");
      host_read(DEPTH - 1, 1'b1);
      check("R5 last entry kept", int'(rd_o), ((DEPTH - 1) * 7 + 3) & 255);
      host_read(0, 1'b1);
      check("R5 first entry", int'(rd_o), 3);
      for (int i = 0; i < 6; i++) host_read(int'($urandom_range(DEPTH - 1)), 1'b1);

      // R2: re-arm after full clears the flag.
      arm_capture("R2");
      check("R2 full cleared", int'(st_full), 0);
      check("R2 count cleared", int'(st_addr), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule